// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Block

This block is a byte-wide general-purpose I/O port controlled over a simple single-cycle register bus. It holds two control registers: a direction mask, which decides per bit whether the pin is driven, and an output latch, which supplies the driven value. A third address exposes a read-only view of the port. In that view, each bit returns the latch bit when the pin is driven and the synchronized pin level when it is not.

The block drives a per-pin output enable and a per-pin output value, and it samples the pins through a multi-stage synchronizer. It takes four separate control conditions:

- **Power-on reset** wipes all state.
- **Hardware standby** clears the direction mask and output latch and floats every pin.
- **Manual reset** freezes the registers and the sampled pin view, and blocks bus writes.
- **Software standby** behaves the same way as manual reset.

Top module: `gpio_port_regs`

## Requirements
- R1: While `rst_n` is low at a rising edge, the direction mask, output latch and synchronizer stages are cleared. After that edge, `pin_oe` and `pin_out` are all zeros and a port read returns the synchronized pin level.
- R2: A bus write to offset 1 (output latch) loads `bus_wdata` at the rising edge. A read of offset 1 returns the latched value.
- R3: A bus write to offset 0 (direction mask, 1 = drive) loads the mask at the edge. A read of offset 0 always returns all ones.
- R4: A read of offset 2 (port view) returns, for each bit, the latch bit when the mask bit is 1, and the synchronized pin bit when the mask bit is 0.
- R5: A pin change becomes visible in the port view after exactly two rising edges, and not after one.
- R6: A bus write to offset 2 changes no state: the outputs and every readable register keep their values.
- R7: A read of offset 3 (unmapped) returns zero.
- R8: While `hw_stby` is high, `pin_oe` is all zeros in the same cycle. At each edge in that state, the mask and latch clear to zero and bus writes are ignored.
- R9: While `mrst_n` is low, the mask and latch keep their contents, bus writes are ignored and the synchronizer holds its last value.
- R10: While `sw_stby` is high, the behaviour is the same as in R9.
- R11: Outside hardware standby, `pin_oe` equals the direction mask and `pin_out` equals the output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| mrst_n | input | 1 | Manual reset, active low; holds state |
| hw_stby | input | 1 | Hardware standby; clears state and floats pins |
| sw_stby | input | 1 | Software standby; holds state |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, combinational from offset |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_oe | output | WIDTH | Per-pin output enable |
| pin_out | output | WIDTH | Per-pin output value |

## Verification
The bench builds the block with `WIDTH=4` and the default two-stage synchronizer. At that width, every combination of direction mask, latch value and pin pattern (4096 cases) can be swept, and each port-view bit is checked against the arithmetic mux expectation. The narrow port also keeps the retention sequences short, so that manual reset, software standby and hardware standby can each be entered from a non-trivial state and the preserved or cleared contents read back.

// File: rtl/gpio_port_pkg.sv
// Package: shared register offsets and operating-mode type for the GPIO port.
// Assumes the bus address is at least two bits wide.
package gpio_port_pkg;
    localparam int unsigned OFS_DIR  = 0;
    localparam int unsigned OFS_DATA = 1;
    localparam int unsigned OFS_PORT = 2;

    // Operating mode after resolving reset and standby priority.
    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_CLEAR = 2'd2
    } port_mode_e;
endpackage

// File: rtl/gpio_pin_sync.sv
// Module: multi-stage synchronizer for the pin inputs, with a hold enable.
// Assumes pins are asynchronous; when hold is high every stage keeps its value.
module gpio_pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [WIDTH-1:0] pin_raw,
    output logic [WIDTH-1:0] pin_sync
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: one flop stage, fed by the pins or the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg[s] <= '0;
                end else if (!hold) begin
                    if (s == 0) stg[s] <= pin_raw;
                    else        stg[s] <= stg[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign pin_sync = stg[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
// Module: direction mask and output latch with mode-dependent update rules.
// Assumes mode is already resolved: CLEAR wipes, HOLD freezes, RUN accepts writes.
module gpio_ctrl_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_mode_e        mode,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  data_q
);
    logic wr_dir;
    logic wr_data;

    // Purpose: decode write strobes, accepted only in run mode.
    always_comb begin
        wr_dir  = bus_wr && (mode == MODE_RUN) && (bus_addr == ADDR_W'(OFS_DIR));
        wr_data = bus_wr && (mode == MODE_RUN) && (bus_addr == ADDR_W'(OFS_DATA));
    end

    // Purpose: direction mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n || mode == MODE_CLEAR) dir_q <= '0;
        else if (wr_dir)                  dir_q <= bus_wdata;
    end

    // Purpose: output latch storage.
    always_ff @(posedge clk) begin
        if (!rst_n || mode == MODE_CLEAR) data_q <= '0;
        else if (wr_data)                 data_q <= bus_wdata;
    end
endmodule

// File: rtl/gpio_read_mux.sv
// Module: read data selection, including the per-bit port view.
// Assumes a purely combinational read with no side effects.
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  dir_q,
    input  logic [WIDTH-1:0]  data_q,
    input  logic [WIDTH-1:0]  pin_sync,
    output logic [WIDTH-1:0]  bus_rdata
);
    logic [WIDTH-1:0] port_view;

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            // Purpose: per-bit source choice between latch and pin.
            assign port_view[b] = dir_q[b] ? data_q[b] : pin_sync[b];
        end
    endgenerate

    // Purpose: select the register addressed by the bus.
    always_comb begin
        if (bus_addr == ADDR_W'(OFS_DIR))       bus_rdata = '1;
        else if (bus_addr == ADDR_W'(OFS_DATA)) bus_rdata = data_q;
        else if (bus_addr == ADDR_W'(OFS_PORT)) bus_rdata = port_view;
        else                                    bus_rdata = '0;
    end
endmodule

// File: rtl/gpio_port_regs.sv
// Module: top level of the GPIO port register block.
// Resolves reset and standby priority, then wires the registers, the synchronizer,
// the read mux and the pin drivers. Assumes all control inputs are synchronous to clk.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_out
);
    port_mode_e       mode;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] pin_sync;

    // Purpose: resolve priority; hardware standby wins over the holding conditions.
    always_comb begin
        if (hw_stby)                mode = MODE_CLEAR;
        else if (!mrst_n || sw_stby) mode = MODE_HOLD;
        else                        mode = MODE_RUN;
    end

    gpio_ctrl_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .dir_q     (dir_q),
        .data_q    (data_q)
    );

    gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (mode == MODE_HOLD),
        .pin_raw  (pin_in),
        .pin_sync (pin_sync)
    );

    gpio_read_mux #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rmux (
        .bus_addr  (bus_addr),
        .dir_q     (dir_q),
        .data_q    (data_q),
        .pin_sync  (pin_sync),
        .bus_rdata (bus_rdata)
    );

    // Purpose: pin drivers; hardware standby floats every pin.
    always_comb begin
        pin_oe  = hw_stby ? '0 : dir_q;
        pin_out = data_q;
    end
endmodule

// File: rtl/gpio_port_regs_chk.sv
// Module: assertion checker for gpio_port_regs, attached with bind.
// Assumes the port-level names of the top module.
module gpio_port_regs_chk #(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mrst_n,
    input logic              hw_stby,
    input logic              sw_stby,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  pin_in,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  pin_out
);
    logic run;
    assign run = mrst_n && !hw_stby && !sw_stby;

    p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bus_wr && bus_addr == ADDR_W'(1)) |=> (pin_out == $past(bus_wdata)));

    p_dir_reads_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(0)) |-> (bus_rdata == '1));

    p_driven_port_view_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(2) && pin_oe == '1) |-> (bus_rdata == pin_out));

    p_port_write_noeffect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(2) && !hw_stby) |=> $stable(pin_out));

    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(3)) |-> (bus_rdata == '0));

    p_hw_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |-> (pin_oe == '0));

    p_hw_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (pin_out == '0));

    p_hold_mrst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mrst_n && !hw_stby) |=> $stable(pin_out));

    p_hold_swstby_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> $stable(pin_out));

    // R11: with no write and no clearing, the enable never changes between cycles.
    p_oe_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !hw_stby) |=> (hw_stby || pin_oe == $past(pin_oe)));

    // R1: pins and other inputs are unused by some properties; touch them to keep all ports observed.
    logic unused_ok;
    assign unused_ok = ^pin_in;
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_gpio_port_regs.sv
// Bench: sweeps every direction/latch/pin combination at WIDTH=4 and walks the
// reset and standby sequences, computing expected values arithmetically.
module test_gpio_port_regs;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 4;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mrst_n = 1'b1;
    logic          hw_stby = 1'b0;
    logic          sw_stby = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pin_in = '0;
    logic [W-1:0]  pin_oe;
    logic [W-1:0]  pin_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_regs #(.WIDTH(W), .ADDR_W(AW), .SYNC_STAGES(2)) i_gpio_port_regs (
        .clk(clk), .rst_n(rst_n), .mrst_n(mrst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    function automatic logic [W-1:0] view(input logic [W-1:0] d, input logic [W-1:0] q,
                                          input logic [W-1:0] p);
        return (d & q) | (~d & p);
    endfunction

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    logic [W-1:0] r;

    initial begin
        #(CLK_PERIOD*190000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        pin_in = 4'h9;
        tick(3);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 oe", pin_oe, '0);
        check("R1 out", pin_out, '0);
        rd(2'd1, r); check("R1 data", r, '0);
        tick(2);
        rd(2'd2, r); check("R1 port=pins", r, 4'h9);
        // R3 / R7
        rd(2'd0, r); check("R3 dir reads ones", r, 4'hF);
        rd(2'd3, r); check("R7 unmapped", r, 4'h0);

        // R2 R4 R11: exhaustive sweep
        for (int d = 0; d < 16; d++) begin
            for (int q = 0; q < 16; q++) begin
                wr(2'd0, W'(d));
                wr(2'd1, W'(q));
                check("R11 oe", pin_oe, W'(d));
                check("R11 out", pin_out, W'(q));
                rd(2'd1, r); check("R2 readback", r, W'(q));
                for (int p = 0; p < 16; p++) begin
                    pin_in = W'(p);
                    tick(2);
                    rd(2'd2, r); check("R4 port view", r, view(W'(d), W'(q), W'(p)));
                end
            end
        end

        // R5: latency
        wr(2'd0, 4'h0);
        pin_in = 4'h3; tick(3);
        pin_in = 4'hC; tick(1);
        rd(2'd2, r); check("R5 not after one", r, 4'h3);
        tick(1);
        rd(2'd2, r); check("R5 after two", r, 4'hC);

        // R6: write to port offset
        wr(2'd0, 4'h6); wr(2'd1, 4'h5);
        wr(2'd2, 4'hA);
        check("R6 out", pin_out, 4'h5);
        check("R6 oe", pin_oe, 4'h6);
        rd(2'd1, r); check("R6 data", r, 4'h5);
        rd(2'd2, r); check("R6 port", r, view(4'h6, 4'h5, 4'hC));

        // R9: manual reset retains and freezes
        wr(2'd0, 4'h5); wr(2'd1, 4'hA);
        pin_in = 4'h3; tick(3);
        mrst_n = 1'b0;
        wr(2'd1, 4'hF); wr(2'd0, 4'h0);
        pin_in = 4'hC; tick(3);
        check("R9 out held", pin_out, 4'hA);
        check("R9 oe held", pin_oe, 4'h5);
        rd(2'd2, r); check("R9 port frozen", r, view(4'h5, 4'hA, 4'h3));
        mrst_n = 1'b1; tick(2);
        rd(2'd2, r); check("R9 port resumes", r, view(4'h5, 4'hA, 4'hC));

        // R10: software standby same
        sw_stby = 1'b1;
        wr(2'd1, 4'h1);
        pin_in = 4'h0; tick(3);
        check("R10 out held", pin_out, 4'hA);
        rd(2'd2, r); check("R10 port frozen", r, view(4'h5, 4'hA, 4'hC));
        sw_stby = 1'b0; tick(2);
        rd(2'd2, r); check("R10 port resumes", r, view(4'h5, 4'hA, 4'h0));

        // R8: hardware standby clears and floats
        wr(2'd0, 4'hF); wr(2'd1, 4'h5);
        pin_in = 4'h6;
        hw_stby = 1'b1; #1;
        check("R8 oe float same cycle", pin_oe, 4'h0);
        wr(2'd1, 4'hE);
        check("R8 out cleared", pin_out, 4'h0);
        tick(1);
        hw_stby = 1'b0; #1;
        check("R8 oe after", pin_oe, 4'h0);
        rd(2'd1, r); check("R8 data cleared", r, 4'h0);
        rd(2'd2, r); check("R8 port=pins", r, 4'h6);

        // R1: power-on reset again from non-zero state
        wr(2'd0, 4'h3); wr(2'd1, 4'h3);
        rst_n = 1'b0; tick(1); rst_n = 1'b1; #1;
        check("R1 oe after reset", pin_oe, 4'h0);
        check("R1 out after reset", pin_out, 4'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule